// File: doc/BRIEF.md
# Keypad Scanner with Confirmation Tone

This block watches a telephone keypad of four rows and three driven columns. A fourth column of keys has no line of its own: each of those keys shorts its row straight to ground. While idle and off-hook the block pulls the rows high and drives the columns low. It waits for a row to drop. It then flips the line roles for one cycle, with the columns pulled high and the rows driven low, to read which column carries the key.

After that first look it ignores the keypad for a fixed debounce time of 32 timing ticks, where one tick stands for one millisecond. It then reads both phases again. It accepts the key only if the second reading matches the first exactly. An accepted key is reported as a 4-bit code with a one-cycle strobe and a held level. In tone mode, a double press that shares a row or a column is reported as a single-tone code.

An audible confirmation output gives a 500 Hz square wave for up to 75 ticks. Which keys produce it depends on the dial mode. Any change on the hook input throws away whatever scan is in progress.

Top module: `kps_scanner`

## Requirements
- R1: While no row is low, or while `hook_i` is 1 (on-hook), `col_phase_o` stays 0 and no key is reported.
- R2: When a row reads low in the idle state, `col_phase_o` is 1 for exactly one cycle to capture the columns. A row that is low with no column low is a ground-column key. Between a press and its acceptance, `col_phase_o` is high in exactly two cycles.
- R3: The debounce timer starts after the column capture. On its 32nd tick the rows are read again, and in the next cycle the columns are read again. `key_vld_o` pulses for one cycle in the following cycle, but only when both readings equal the first capture. A change of key during debounce gives no strobe.
- R4: Codes use rows numbered 0..3 from top to bottom and columns 0..2 from left to right. Rows 0..2 give the digits 3r+c+1. Row 3 gives 10 (star), 0 and 11 (hash). A ground-column key on row r gives 12+r, in the order flash, pause, redial, tone-switch. `key_o` and `single_o` hold their values until the next strobe.
- R5: In tone mode, two or more keys in one row r give `single_o`=1 with code r. One column c pressed on two or more rows gives `single_o`=1 with code 4+c. In pulse mode, such patterns are rejected.
- R6: The tone output goes to 1 in the strobe cycle and toggles on each tick. It is forced to 0 on the 75th tick, which makes 76 transitions in all, and it stays 0 otherwise.
- R7: In pulse mode every accepted key starts the tone. In tone mode only codes 12..15 start it.
- R8: Releasing the key (all rows high) stops the tone in the next cycle.
- R9: Any change of `hook_i` aborts the scan. `held_o`, `key_vld_o` and `pac_o` are 0 in the next cycle, and the interrupted press is never reported.
- R10: `held_o` rises with the strobe and falls in the cycle after all rows read high. Further presses while a key is held are not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timing pulse, one per millisecond |
| hook_i | input | 1 | 1 = on-hook, 0 = off-hook |
| tone_mode_i | input | 1 | 1 = tone dialing, 0 = pulse dialing |
| row_i | input | 4 | Sampled row lines, active low |
| col_i | input | 3 | Sampled column lines, active low |
| col_phase_o | output | 1 | 1 = columns pulled up and rows driven low; 0 = rows pulled up and columns driven low |
| key_vld_o | output | 1 | One-cycle strobe for an accepted key |
| key_o | output | 4 | Key code or single-tone code |
| single_o | output | 1 | Code is a single-tone test code and must not be stored |
| held_o | output | 1 | Accepted key still pressed |
| pac_o | output | 1 | Confirmation square wave |

## Verification
The assertions take several things for granted about the inputs. `row_i` and `col_i` are synchronous to the clock, and they settle within the same cycle that `col_phase_o` changes. `tick_i` is a single-cycle pulse, with pulses several cycles apart. The stimulus keeps within this. A combinational keypad model derives the line levels from the pressed-key set and the phase output. Key changes happen on the falling clock edge just after a tick, and hold times are long enough to cover the full debounce and tone windows.

// File: rtl/kps_pkg.sv
package kps_pkg;
  localparam int KP_ROWS = 4;
  localparam int KP_COLS = 3;
  localparam int RIW = $clog2(KP_ROWS);
  localparam int CIW = $clog2(KP_COLS);
  localparam int NRW = $clog2(KP_ROWS + 1);
  localparam int NCW = $clog2(KP_COLS + 1);

  localparam logic [3:0] CODE_ZERO    = 4'd0;
  localparam logic [3:0] CODE_STAR    = 4'd10;
  localparam logic [3:0] CODE_HASH    = 4'd11;
  localparam logic [3:0] CODE_FN_BASE = 4'd12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COLSET,
    ST_DEB,
    ST_CHKCOL,
    ST_HELD,
    ST_WAIT
  } kps_state_e;

  typedef struct packed {
    logic       valid;
    logic       single;
    logic       fn;
    logic [3:0] code;
  } kps_key_t;
endpackage

// File: rtl/kps_decode.sv
module kps_decode
  import kps_pkg::*;
(
  input  logic [KP_ROWS-1:0] row_low,
  input  logic [KP_COLS-1:0] col_low,
  input  logic               tone_mode,
  output kps_key_t           key
);
  logic [NRW-1:0] nr;
  logic [NCW-1:0] nc;
  logic [RIW-1:0] ri;
  logic [CIW-1:0] ci;

  always_comb begin
    nr = '0;
    nc = '0;
    ri = '0;
    ci = '0;
    for (int r = 0; r < KP_ROWS; r++) begin
      if (row_low[r]) begin
        nr = nr + 1'b1;
        ri = RIW'(r);
      end
    end
    for (int c = 0; c < KP_COLS; c++) begin
      if (col_low[c]) begin
        nc = nc + 1'b1;
        ci = CIW'(c);
      end
    end

    key = '0;
    if (nr == NRW'(1) && nc == '0) begin
      key.valid = 1'b1;
      key.fn    = 1'b1;
      key.code  = CODE_FN_BASE + 4'(ri);
    end else if (nr == NRW'(1) && nc == NCW'(1)) begin
      key.valid = 1'b1;
      if (ri != RIW'(KP_ROWS - 1)) begin
        key.code = 4'(ri) * 4'd3 + 4'(ci) + 4'd1;
      end else begin
        case (ci)
          CIW'(0): key.code = CODE_STAR;
          CIW'(1): key.code = CODE_ZERO;
          default: key.code = CODE_HASH;
        endcase
      end
    end else if (tone_mode && nr == NRW'(1) && nc >= NCW'(2)) begin
      key.valid  = 1'b1;
      key.single = 1'b1;
      key.code   = 4'(ri);
    end else if (tone_mode && nr >= NRW'(2) && nc == NCW'(1)) begin
      key.valid  = 1'b1;
      key.single = 1'b1;
      key.code   = 4'(KP_ROWS) + 4'(ci);
    end
  end
endmodule

// File: rtl/kps_tick_timer.sv
module kps_tick_timer #(
  parameter int LIMIT = 32
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  input  logic clear_i,
  input  logic tick_i,
  output logic busy_o,
  output logic last_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i) begin
      cnt <= '0;
    end else if (start_i) begin
      cnt <= CW'(LIMIT);
    end else if (tick_i && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy_o = (cnt != '0);
  assign last_o = (cnt == CW'(1));

  // R3
  load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !clear_i) |=> (cnt == CW'(LIMIT)));

  // R6
  count_down_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && busy_o && !start_i && !clear_i) |=> (cnt == CW'($past(cnt) - 1'b1)));
endmodule

// File: rtl/kps_pacifier.sv
module kps_pacifier #(
  parameter int PAC_TICKS = 75
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic tick_i,
  output logic tone_o
);
  logic busy;
  logic last;
  logic tone_q;

  kps_tick_timer #(.LIMIT(PAC_TICKS)) u_len (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start_i),
    .clear_i (stop_i),
    .tick_i  (tick_i),
    .busy_o  (busy),
    .last_o  (last)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i || stop_i) begin
      tone_q <= 1'b0;
    end else if (start_i) begin
      tone_q <= 1'b1;
    end else if (tick_i && busy) begin
      tone_q <= last ? 1'b0 : ~tone_q;
    end
  end

  assign tone_o = tone_q;

  // R6
  pac_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!start_i && !stop_i && !tick_i) |=> $stable(tone_q));

  // R6
  pac_idle_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy |-> !tone_q);

  // R8
  pac_stop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    stop_i |=> !tone_q);
endmodule

// File: rtl/kps_scanner.sv
module kps_scanner
  import kps_pkg::*;
#(
  parameter int DEBOUNCE_TICKS = 32,
  parameter int PAC_TICKS      = 75
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               tick_i,
  input  logic               hook_i,
  input  logic               tone_mode_i,
  input  logic [KP_ROWS-1:0] row_i,
  input  logic [KP_COLS-1:0] col_i,
  output logic               col_phase_o,
  output logic               key_vld_o,
  output logic [3:0]         key_o,
  output logic               single_o,
  output logic               held_o,
  output logic               pac_o
);
  kps_state_e       state;
  logic             hook_q;
  logic [KP_ROWS-1:0] row_cap;
  logic [KP_COLS-1:0] col_cap;
  logic             row_ok_q;
  logic             col_phase_q;
  logic             key_vld_q;
  logic [3:0]       key_q;
  logic             single_q;
  logic             held_q;

  kps_key_t dec;
  logic     abort;
  logic     released;
  logic     deb_start;
  logic     deb_busy;
  logic     deb_last;
  logic     accept;
  logic     pac_start;
  logic     pac_stop;

  kps_decode u_dec (
    .row_low   (row_cap),
    .col_low   (col_cap),
    .tone_mode (tone_mode_i),
    .key       (dec)
  );

  assign abort     = hook_i || (hook_i != hook_q);
  assign released  = &row_i;
  assign deb_start = (state == ST_COLSET) && !abort;
  assign accept    = (state == ST_CHKCOL) && !abort && row_ok_q
                     && (~col_i == col_cap) && dec.valid;
  assign pac_start = accept && (!tone_mode_i || dec.fn);
  assign pac_stop  = abort || ((state == ST_HELD) && released);

  kps_tick_timer #(.LIMIT(DEBOUNCE_TICKS)) u_deb (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (deb_start),
    .clear_i (abort),
    .tick_i  (tick_i),
    .busy_o  (deb_busy),
    .last_o  (deb_last)
  );

  kps_pacifier #(.PAC_TICKS(PAC_TICKS)) u_pac (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (pac_start),
    .stop_i  (pac_stop),
    .tick_i  (tick_i),
    .tone_o  (pac_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state       <= ST_IDLE;
      hook_q      <= 1'b1;
      row_cap     <= '0;
      col_cap     <= '0;
      row_ok_q    <= 1'b0;
      col_phase_q <= 1'b0;
      key_vld_q   <= 1'b0;
      key_q       <= '0;
      single_q    <= 1'b0;
      held_q      <= 1'b0;
    end else begin
      hook_q    <= hook_i;
      key_vld_q <= 1'b0;
      if (abort) begin
        state       <= ST_IDLE;
        col_phase_q <= 1'b0;
        held_q      <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (!released) begin
              row_cap     <= ~row_i;
              col_phase_q <= 1'b1;
              state       <= ST_COLSET;
            end
          end
          ST_COLSET: begin
            col_cap     <= ~col_i;
            col_phase_q <= 1'b0;
            state       <= ST_DEB;
          end
          ST_DEB: begin
            if (tick_i && deb_last) begin
              row_ok_q    <= (~row_i == row_cap);
              col_phase_q <= 1'b1;
              state       <= ST_CHKCOL;
            end
          end
          ST_CHKCOL: begin
            col_phase_q <= 1'b0;
            if (accept) begin
              key_vld_q <= 1'b1;
              key_q     <= dec.code;
              single_q  <= dec.single;
              held_q    <= 1'b1;
              state     <= ST_HELD;
            end else begin
              state <= ST_WAIT;
            end
          end
          ST_HELD: begin
            if (released) begin
              held_q <= 1'b0;
              state  <= ST_IDLE;
            end
          end
          ST_WAIT: begin
            if (released) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign col_phase_o = col_phase_q;
  assign key_vld_o   = key_vld_q;
  assign key_o       = key_q;
  assign single_o    = single_q;
  assign held_o      = held_q;

  // R1
  onhook_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    hook_i |=> (!col_phase_q && state == ST_IDLE));

  // R2
  colphase_brief_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    col_phase_q |=> !col_phase_q);

  // R3
  vld_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    key_vld_q |=> !key_vld_q);

  // R3
  deb_running_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (state == ST_DEB) |-> deb_busy);

  // R9
  hook_abort_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hook_i != hook_q) |=> (!held_q && !key_vld_q && !pac_o));

  // R10
  held_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(held_q) |-> key_vld_q);

  // R10
  held_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (held_q && released && !col_phase_q) |=> !held_q);
endmodule

// File: tb/tb_kps_scanner.sv
module tb_kps_scanner;
  localparam int TICK_CYC = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic       hook_i = 1'b0;
  logic       tone_mode_i = 1'b0;
  logic [3:0] row_i;
  logic [2:0] col_i;
  logic       col_phase_o, key_vld_o, single_o, held_o, pac_o;
  logic [3:0] key_o;
  logic [15:0] press = '0;   // bit r*4+c, c=3 is the ground column
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tcnt = 0;

  always #2 clk = ~clk;

  kps_scanner dut (
    .clk_i(clk), .rst_i(rst), .tick_i(tick_i), .hook_i(hook_i),
    .tone_mode_i(tone_mode_i), .row_i(row_i), .col_i(col_i),
    .col_phase_o(col_phase_o), .key_vld_o(key_vld_o), .key_o(key_o),
    .single_o(single_o), .held_o(held_o), .pac_o(pac_o)
  );

  // keypad model
  always_comb begin
    row_i = '1;
    col_i = '0;
    if (col_phase_o) begin
      row_i = '0;
      for (int c = 0; c < 3; c++)
        col_i[c] = ~(press[c] | press[4+c] | press[8+c] | press[12+c]);
    end else begin
      for (int r = 0; r < 4; r++) row_i[r] = ~(|press[r*4 +: 4]);
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      tcnt   <= 0;
      tick_i <= 1'b0;
    end else begin
      tcnt   <= (tcnt == TICK_CYC-1) ? 0 : tcnt + 1;
      tick_i <= (tcnt == TICK_CYC-1);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_code(input int r, input int c);
    if (c == 3) return 4'(12 + r);
    if (r < 3)  return 4'(3*r + c + 1);
    if (c == 0) return 4'd10;
    if (c == 1) return 4'd0;
    return 4'd11;
  endfunction

  task automatic sync_tick();
    do @(negedge clk); while (!tick_i);
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (tick_i) k++;
    end
  endtask

  // watches a window; counts strobes, column-phase cycles and tone edges
  task automatic watch(input int n, output int vlds, output int cps, output int edges);
    int k = 0;
    logic prev = pac_o;
    vlds = 0; cps = 0; edges = 0;
    while (k < n) begin
      @(negedge clk);
      if (tick_i) k++;
      if (key_vld_o) vlds++;
      if (col_phase_o) cps++;
      if (pac_o != prev) edges++;
      prev = pac_o;
    end
  endtask

  task automatic key_run(input logic [15:0] pat, input logic tone, input logic exp_vld,
                         input logic [3:0] ecode, input logic esing, input logic epac);
    int n = 0, cp = 0, v, c2, edges;
    logic got = 1'b0;
    logic [3:0] k = '0;
    logic s = 1'b0;
    @(negedge clk);
    tone_mode_i = tone;
    sync_tick();
    press = pat;
    while (!got && n < 40) begin
      @(negedge clk);
      if (tick_i) n++;
      if (col_phase_o) cp++;
      if (key_vld_o) begin got = 1'b1; k = key_o; s = single_o; end
    end
    if (exp_vld) begin
      check(got, "R3 strobe seen", int'(got), 1);
      check(n == 32, "R3 debounce ticks", n, 32);
      check(cp == 2, "R2 column phase cycles", cp, 2);
      check(k == ecode, "R4/R5 key code", int'(k), int'(ecode));
      check(s == esing, "R5 single flag", int'(s), int'(esing));
      check(held_o == 1'b1, "R10 held after strobe", int'(held_o), 1);
      check(pac_o == epac, "R7 tone start", int'(pac_o), int'(epac));
      watch(80, v, c2, edges);
      check(edges == (epac ? 75 : 0), "R6 tone edges after start", edges, epac ? 75 : 0);
      check(v == 0, "R10 no strobe while held", v, 0);
      check(pac_o == 1'b0, "R6 tone ends low", int'(pac_o), 0);
    end else begin
      check(!got, "R3/R5 no strobe", int'(got), 0);
    end
    press = '0;
    repeat (3) @(negedge clk);
    check(held_o == 1'b0, "R10 held drops on release", int'(held_o), 0);
    wait_ticks(2);
  endtask

  initial begin
    int v, cp, edges;
    void'($urandom(32'd1917));
    repeat (4) @(negedge clk);
    check(!key_vld_o && !held_o && !pac_o && !col_phase_o && key_o == 4'd0 && !single_o,
          "R1 reset state", int'({key_vld_o, held_o, pac_o, col_phase_o}), 0);
    rst = 1'b0;

    // R1: idle, no activity
    watch(20, v, cp, edges);
    check(v == 0 && cp == 0, "R1 idle quiet", v + cp, 0);

    // R1: on-hook, key pressed, no scanning
    hook_i = 1'b1;
    press[5] = 1'b1;
    watch(40, v, cp, edges);
    check(v == 0 && cp == 0, "R1 on-hook no scan", v + cp, 0);
    press = '0;
    hook_i = 1'b0;
    wait_ticks(2);

    // R4/R6/R7 directed keys
    key_run(16'h0001, 1'b0, 1'b1, 4'd1, 1'b0, 1'b1);          // digit 1, pulse
    key_run(16'h2000, 1'b1, 1'b1, 4'd0, 1'b0, 1'b0);          // digit 0, tone: no tone
    key_run(16'h0008, 1'b1, 1'b1, 4'd12, 1'b0, 1'b1);         // flash, tone
    key_run(16'h8000, 1'b1, 1'b1, 4'd15, 1'b0, 1'b1);         // tone-switch, tone
    key_run(16'h4000, 1'b0, 1'b1, 4'd11, 1'b0, 1'b1);         // hash, pulse

    // R5: single-tone codes and pulse-mode rejection
    key_run(16'h0050, 1'b1, 1'b1, 4'd1, 1'b1, 1'b0);          // row 1, cols 0 and 2
    key_run(16'h0202, 1'b1, 1'b1, 4'd5, 1'b1, 1'b0);          // col 1, rows 0 and 2
    key_run(16'h0050, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0);          // pulse: rejected

    // R3: key change during debounce is rejected
    tone_mode_i = 1'b0;
    sync_tick();
    press = 16'h0001;
    wait_ticks(10);
    press = 16'h0400;
    watch(40, v, cp, edges);
    check(v == 0, "R3 changed key rejected", v, 0);
    press = '0;
    wait_ticks(2);

    // R9: hook change during debounce aborts
    sync_tick();
    press = 16'h0020;
    wait_ticks(10);
    hook_i = 1'b1;
    press = '0;
    repeat (2) @(negedge clk);
    hook_i = 1'b0;
    watch(40, v, cp, edges);
    check(v == 0, "R9 aborted press not reported", v, 0);

    // R9: hook change while held and tone running
    sync_tick();
    press = 16'h0020;
    watch(34, v, cp, edges);
    check(v == 1 && held_o && pac_o, "R9 setup accept", v, 1);
    wait_ticks(5);
    hook_i = 1'b1;
    @(negedge clk);
    check(!held_o && !pac_o && !key_vld_o, "R9 abort clears outputs",
          int'({held_o, pac_o, key_vld_o}), 0);
    press = '0;
    hook_i = 1'b0;
    wait_ticks(3);

    // R8: early release stops tone
    sync_tick();
    press = 16'h0004;
    watch(34, v, cp, edges);
    check(v == 1, "R8 setup accept", v, 1);
    wait_ticks(10);
    press = '0;
    repeat (2) @(negedge clk);
    check(!pac_o && !held_o, "R8 tone stops on release", int'({pac_o, held_o}), 0);
    watch(20, v, cp, edges);
    check(edges == 0, "R8 tone stays off", edges, 0);

    // R10: second key while held is ignored, then accepted after release
    sync_tick();
    press = 16'h0001;
    watch(34, v, cp, edges);
    check(v == 1, "R10 first key", v, 1);
    press[5] = 1'b1;
    watch(50, v, cp, edges);
    check(v == 0, "R10 second key ignored while held", v, 0);
    press = '0;
    wait_ticks(2);
    key_run(16'h0020, 1'b0, 1'b1, 4'd5, 1'b0, 1'b1);

    // random single keys, R4 R6 R7
    for (int i = 0; i < 30; i++) begin
      int r = $urandom % 4;
      int c = $urandom % 4;
      logic t = 1'($urandom % 2);
      key_run(16'(1) << (r*4 + c), t, 1'b1, exp_code(r, c), 1'b0, !t || c == 3);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule